// File: doc/BRIEF.md
# Interrupt Mask and Priority Register Bank

This block holds the mask and priority registers of an interrupt controller and turns every write into a stream of per-field enable and disable events. Each mask register stores one enable bit per interrupt source. Each priority register is split into fixed-width fields, one per source. A register is reached either through a pair of addresses, one that sets bits and one that clears them, or, for priority registers built that way, through one address that overwrites it. A write stores the new value at once. It then compares the new value with the old one field by field. For each field that changed, one event goes out naming the source and whether the field now enables or disables it. A downstream aggregator uses these events to keep its per-source enable counts.

Requests arrive on a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The port holds `req_ready` low while the events of the last write are still draining, so that write back-pressure reaches the bus. Each accepted request gets exactly one response pulse. The response has no ready input and cannot be stalled. Events leave on a second valid/ready stream. An event that is not taken stays on the pins unchanged until `ev_ready` accepts it.

Top module: `intc_mask_prio_bank`

## Requirements
- R1: Only bits [28:0] of `req_addr` take part in address matching. Bits above them are ignored.
- R2: A write to the set address of a paired register stores the old value OR the write data.
- R3: A write to the clear address of a paired register stores the old value AND the inverted write data.
- R4: A priority register with a single address stores the write data as given. The word 4 bytes above that address is unmapped for it. Register n of a kind has its set (or single) address at base + 8n, and its clear address, when it has one, at base + 8n + 4.
- R5: A read of either address of a register returns its stored value in `rsp_rdata` with `rsp_err` low. A read changes no state and emits no event.
- R6: Mask fields are single bits. Priority fields are FIELD_W bits wide, and there are REG_W/FIELD_W of them. Each field whose value changed emits one event, and `ev_enable` is 1 exactly when the new field value is nonzero. Fields are counted from the most significant one (k = 0). The source id of field k is n*REG_W + k for mask register n, and NUM_MASK*REG_W + n*(REG_W/FIELD_W) + k for priority register n.
- R7: The events of one write leave in order from the most significant changed field to the least significant one. Their source ids therefore rise strictly.
- R8: A field mapped to source id 0 never emits an event, although its stored bit still changes.
- R9: A request to an unmapped address returns `rsp_err` = 1 with `rsp_rdata` = 0. If it is a write, it changes no register and emits no event.
- R10: The first event appears in the cycle after the write is accepted. Exactly one event is presented per cycle. An event is held until `ev_ready` is high. `req_ready` stays low from that cycle until the edge that accepts the last event, and a write with no changed field leaves `req_ready` high.
- R11: Each accepted request produces `rsp_valid` high for exactly the one cycle after acceptance. `rsp_valid` is low in every other cycle.
- R12: When a mask register address and a priority register address coincide, the mask register is the one accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears all registers |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request (low while events drain) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | REG_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | REG_W | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Request hit no register |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Consumer takes the event |
| ev_src | output | SRC_W | Source id of the event |
| ev_enable | output | 1 | 1 = enable, 0 = disable |

## Verification
The bench builds the bank with 8-bit registers, two mask registers, three priority registers and 2-bit priority fields. Priority register 1 is paired and register 2 has a single address. The priority base lies 8 bytes above the mask base, so mask register 1 shadows priority register 0. With these values every write mode and the unmapped word above a single-address register can be reached. The shadowing case (R12) and the reserved source id 0 at the top bit of mask register 0 can be reached too. Bursts of up to eight events are short enough for random `ev_ready` stalls to land at every position in a burst.

// File: rtl/intc_bank_pkg.sv
package intc_bank_pkg;
  typedef enum logic [1:0] {
    OP_NONE,
    OP_SET,
    OP_CLR,
    OP_DIRECT
  } wr_op_e;
endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
  import intc_bank_pkg::*;
#(
  parameter int unsigned NUM_MASK  = 2,
  parameter int unsigned NUM_PRIO  = 2,
  parameter int unsigned IDX_W     = 1,
  parameter int unsigned MASK_BASE = 'h100,
  parameter int unsigned PRIO_BASE = 'h200,
  parameter logic [NUM_PRIO-1:0] PRIO_DUAL = '1
) (
  input  logic [28:0]      addr_i,
  output logic             hit_o,
  output logic             prio_o,
  output logic [IDX_W-1:0] idx_o,
  output wr_op_e           op_o
);
  localparam int unsigned LOW_W = 29;

  // Priority registers are matched first and mask registers after, so a
  // mask match overrides: mask registers win on shared addresses.
  always_comb begin
    hit_o  = 1'b0;
    prio_o = 1'b0;
    idx_o  = '0;
    op_o   = OP_NONE;
    for (int j = NUM_PRIO - 1; j >= 0; j--) begin
      if (addr_i == LOW_W'(PRIO_BASE + 8 * j)) begin
        hit_o  = 1'b1;
        prio_o = 1'b1;
        idx_o  = IDX_W'(j);
        op_o   = PRIO_DUAL[j] ? OP_SET : OP_DIRECT;
      end else if (PRIO_DUAL[j] && addr_i == LOW_W'(PRIO_BASE + 8 * j + 4)) begin
        hit_o  = 1'b1;
        prio_o = 1'b1;
        idx_o  = IDX_W'(j);
        op_o   = OP_CLR;
      end
    end
    for (int i = NUM_MASK - 1; i >= 0; i--) begin
      if (addr_i == LOW_W'(MASK_BASE + 8 * i)) begin
        hit_o  = 1'b1;
        prio_o = 1'b0;
        idx_o  = IDX_W'(i);
        op_o   = OP_SET;
      end else if (addr_i == LOW_W'(MASK_BASE + 8 * i + 4)) begin
        hit_o  = 1'b1;
        prio_o = 1'b0;
        idx_o  = IDX_W'(i);
        op_o   = OP_CLR;
      end
    end
  end
endmodule

// File: rtl/intc_field_diff.sv
module intc_field_diff #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned FW    = 1,
  parameter int unsigned SRC_W = 6
) (
  input  logic [REG_W-1:0] old_i,
  input  logic [REG_W-1:0] new_i,
  input  logic [SRC_W-1:0] first_id_i,
  output logic [REG_W-1:0] chg_o
);
  localparam int unsigned NF = REG_W / FW;

  // Position p counts fields from the LSB; its id offset counts from the MSB.
  for (genvar p = 0; p < NF; p++) begin : g_field
    logic [SRC_W-1:0] id;
    assign id       = first_id_i + SRC_W'(NF - 1 - p);
    assign chg_o[p] = (old_i[p*FW +: FW] != new_i[p*FW +: FW]) && (id != '0);
  end

  if (NF < REG_W) begin : g_pad
    assign chg_o[REG_W-1:NF] = '0;
  end
endmodule

// File: rtl/intc_evt_seq.sv
module intc_evt_seq #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned SRC_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REG_W-1:0] chg_i,
  input  logic [REG_W-1:0] val_i,
  input  logic             prio_i,
  input  logic [SRC_W-1:0] first_id_i,
  input  logic             ev_ready_i,
  output logic             busy_o,
  output logic             ev_valid_o,
  output logic [SRC_W-1:0] ev_src_o,
  output logic             ev_enable_o
);
  localparam int unsigned NPF = REG_W / FIELD_W;
  localparam int unsigned PW  = (REG_W > 1) ? $clog2(REG_W) : 1;

  logic [REG_W-1:0] pend_q, val_q;
  logic             prio_q;
  logic [SRC_W-1:0] first_q;
  logic [PW-1:0]    sel;
  logic [SRC_W-1:0] last_off;
  logic [REG_W-1:0] fld;

  // Highest pending position wins: most significant field first.
  always_comb begin
    sel = '0;
    for (int p = 0; p < REG_W; p++) begin
      if (pend_q[p]) sel = PW'(p);
    end
  end

  assign last_off    = prio_q ? SRC_W'(NPF - 1) : SRC_W'(REG_W - 1);
  assign fld         = val_q >> (sel * FIELD_W);
  assign ev_valid_o  = |pend_q;
  assign busy_o      = ev_valid_o;
  assign ev_src_o    = first_q + (last_off - SRC_W'(sel));
  assign ev_enable_o = prio_q ? |fld[FIELD_W-1:0] : val_q[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      val_q   <= '0;
      prio_q  <= 1'b0;
      first_q <= '0;
    end else if (load_i) begin
      pend_q  <= chg_i;
      val_q   <= val_i;
      prio_q  <= prio_i;
      first_q <= first_id_i;
    end else if (ev_valid_o && ev_ready_i) begin
      pend_q[sel] <= 1'b0;
    end
  end

  // R10
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o && !ev_ready_i |=> ev_valid_o && $stable(ev_src_o) && $stable(ev_enable_o));

  // R7
  ev_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_valid_o && ev_ready_i) && ev_valid_o |-> ev_src_o > $past(ev_src_o));

  // R8
  no_rsvd_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o |-> ev_src_o != '0);

  // R10
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o);
endmodule

// File: rtl/intc_mask_prio_bank.sv
module intc_mask_prio_bank
  import intc_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned NUM_MASK  = 2,
  parameter int unsigned NUM_PRIO  = 2,
  parameter int unsigned MASK_BASE = 'h100,
  parameter int unsigned PRIO_BASE = 'h200,
  parameter logic [NUM_PRIO-1:0] PRIO_DUAL = 2'b01,
  localparam int unsigned NPF     = REG_W / FIELD_W,
  localparam int unsigned NUM_SRC = NUM_MASK * REG_W + NUM_PRIO * NPF,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic              rsp_err,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [SRC_W-1:0]  ev_src,
  output logic              ev_enable
);
  localparam int unsigned MAX_REGS = (NUM_MASK > NUM_PRIO) ? NUM_MASK : NUM_PRIO;
  localparam int unsigned IDX_W    = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;

  logic [REG_W-1:0] mask_q [NUM_MASK];
  logic [REG_W-1:0] prio_q [NUM_PRIO];

  logic             hit, is_prio, busy, accept, wr_hit;
  logic [IDX_W-1:0] idx;
  wr_op_e           op;
  logic [REG_W-1:0] old_val, new_val, mask_chg, prio_chg, chg;
  logic [SRC_W-1:0] first_id;
  logic [ADDR_W-30:0] unused_addr_hi;

  assign unused_addr_hi = req_addr[ADDR_W-1:29];

  intc_addr_dec #(
    .NUM_MASK (NUM_MASK),
    .NUM_PRIO (NUM_PRIO),
    .IDX_W    (IDX_W),
    .MASK_BASE(MASK_BASE),
    .PRIO_BASE(PRIO_BASE),
    .PRIO_DUAL(PRIO_DUAL)
  ) u_dec (
    .addr_i(req_addr[28:0]),
    .hit_o (hit),
    .prio_o(is_prio),
    .idx_o (idx),
    .op_o  (op)
  );

  always_comb begin
    old_val = '0;
    if (is_prio) begin
      for (int j = 0; j < NUM_PRIO; j++) if (idx == IDX_W'(j)) old_val = prio_q[j];
    end else begin
      for (int i = 0; i < NUM_MASK; i++) if (idx == IDX_W'(i)) old_val = mask_q[i];
    end
  end

  always_comb begin
    unique case (op)
      OP_SET:    new_val = old_val | req_wdata;
      OP_CLR:    new_val = old_val & ~req_wdata;
      OP_DIRECT: new_val = req_wdata;
      default:   new_val = old_val;
    endcase
  end

  assign first_id = is_prio ? SRC_W'(NUM_MASK * REG_W + idx * NPF)
                            : SRC_W'(idx * REG_W);

  intc_field_diff #(.REG_W(REG_W), .FW(1), .SRC_W(SRC_W)) u_mask_diff (
    .old_i(old_val), .new_i(new_val), .first_id_i(first_id), .chg_o(mask_chg)
  );

  intc_field_diff #(.REG_W(REG_W), .FW(FIELD_W), .SRC_W(SRC_W)) u_prio_diff (
    .old_i(old_val), .new_i(new_val), .first_id_i(first_id), .chg_o(prio_chg)
  );

  assign chg       = is_prio ? prio_chg : mask_chg;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign wr_hit    = accept && req_write && hit;

  intc_evt_seq #(.REG_W(REG_W), .FIELD_W(FIELD_W), .SRC_W(SRC_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wr_hit),
    .chg_i      (chg),
    .val_i      (new_val),
    .prio_i     (is_prio),
    .first_id_i (first_id),
    .ev_ready_i (ev_ready),
    .busy_o     (busy),
    .ev_valid_o (ev_valid),
    .ev_src_o   (ev_src),
    .ev_enable_o(ev_enable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MASK; i++) mask_q[i] <= '0;
      for (int j = 0; j < NUM_PRIO; j++) prio_q[j] <= '0;
    end else if (wr_hit) begin
      for (int i = 0; i < NUM_MASK; i++)
        if (!is_prio && idx == IDX_W'(i)) mask_q[i] <= new_val;
      for (int j = 0; j < NUM_PRIO; j++)
        if (is_prio && idx == IDX_W'(j)) prio_q[j] <= new_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept && !hit;
      rsp_rdata <= (accept && !req_write && hit) ? old_val : '0;
    end
  end

  // R11
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R11
  rsp_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);

  // R9
  bad_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && !hit |=> !ev_valid);

  // R10
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !req_ready);
endmodule

// File: tb/test_intc_mask_prio_bank.sv
module test_intc_mask_prio_bank;
  localparam int RW = 8, FW = 2, NM = 2, NP = 3, NPF = RW / FW;
  localparam int MB = 'h108 - 8, PB = 'h108;
  localparam logic [2:0] PDUAL = 3'b010;
  localparam int SW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ev_ready = 1'b0;
  logic [31:0] req_addr = '0;
  logic [RW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, ev_valid, ev_enable;
  logic [RW-1:0] rsp_rdata;
  logic [SW-1:0] ev_src;

  int checks = 0, errors = 0;
  logic [RW-1:0] mm [NM];
  logic [RW-1:0] pm [NP];
  int exp_src [32];
  int exp_en  [32];
  int exp_n;

  always #5 clk = ~clk;

  intc_mask_prio_bank #(
    .ADDR_W(32), .REG_W(RW), .FIELD_W(FW), .NUM_MASK(NM), .NUM_PRIO(NP),
    .MASK_BASE(MB), .PRIO_BASE(PB), .PRIO_DUAL(PDUAL)
  ) i_intc_mask_prio_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_src(ev_src), .ev_enable(ev_enable)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // kind: 0 none, 1 mask, 2 priority; op: 0 set, 1 clear, 2 direct (R1, R4, R12)
  task automatic decode(input logic [31:0] a, output int kind, output int idx, output int op);
    int lo;
    lo = int'(a & 32'h1FFF_FFFF);
    kind = 0; idx = 0; op = 0;
    for (int j = 0; j < NP; j++) begin
      if (lo == PB + 8*j) begin kind = 2; idx = j; op = PDUAL[j] ? 0 : 2; end
      else if (PDUAL[j] && lo == PB + 8*j + 4) begin kind = 2; idx = j; op = 1; end
    end
    for (int i = 0; i < NM; i++) begin
      if (lo == MB + 8*i) begin kind = 1; idx = i; op = 0; end
      else if (lo == MB + 8*i + 4) begin kind = 1; idx = i; op = 1; end
    end
  endtask

  task automatic do_op(input string tag, input bit wr, input logic [31:0] a, input logic [RW-1:0] d);
    int kind, idx, op, k, first, guard;
    logic [RW-1:0] oldv, newv;
    bit rdy;
    decode(a, kind, idx, op);
    oldv = (kind == 1) ? mm[idx] : (kind == 2) ? pm[idx] : '0;
    newv = (op == 0) ? (oldv | d) : (op == 1) ? (oldv & ~d) : d;
    exp_n = 0;
    if (wr && kind == 1) begin
      first = idx * RW;
      for (int p = RW - 1; p >= 0; p--)
        if (oldv[p] != newv[p] && first + (RW - 1 - p) != 0) begin
          exp_src[exp_n] = first + (RW - 1 - p); exp_en[exp_n] = newv[p]; exp_n++;
        end
    end else if (wr && kind == 2) begin
      first = NM * RW + idx * NPF;
      for (int p = NPF - 1; p >= 0; p--)
        if (oldv[p*FW +: FW] != newv[p*FW +: FW]) begin
          exp_src[exp_n] = first + (NPF - 1 - p); exp_en[exp_n] = (newv[p*FW +: FW] != 0); exp_n++;
        end
    end
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R11 response pulse"}, rsp_valid, 1);
    chk({tag, " R9 error flag"}, rsp_err, kind == 0);
    if (!wr) chk({tag, " R5 R9 read data"}, rsp_rdata, (kind == 0) ? 0 : oldv);
    k = 0;
    while (k < exp_n) begin
      chk({tag, " R10 event present"}, ev_valid, 1);
      if (!ev_valid) break;
      chk({tag, " R6 R7 event source"}, ev_src, exp_src[k]);
      chk({tag, " R6 event enable"}, ev_enable, exp_en[k]);
      chk({tag, " R10 ready held low"}, req_ready, 0);
      rdy = ($urandom_range(0, 3) != 0);
      ev_ready = rdy;
      @(negedge clk);
      if (rdy) k++;
    end
    ev_ready = 1'b0;
    chk({tag, " R8 R10 no extra event"}, ev_valid, 0);
    chk({tag, " R10 ready restored"}, req_ready, 1);
    if (wr && kind == 1) mm[idx] = newv;
    if (wr && kind == 2) pm[idx] = newv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NM; i++) mm[i] = '0;
    for (int j = 0; j < NP; j++) pm[j] = '0;
    repeat (3) @(negedge clk);
    chk("reset R10 ready", req_ready, 1);
    chk("reset R10 no event", ev_valid, 0);
    chk("reset R11 no response", rsp_valid, 0);
    rst_n = 1'b1;
    do_op("reset R5", 1'b0, 32'h100, 8'h00);
    // R8: top bit of mask 0 is source 0
    do_op("R2 R8 set all", 1'b1, 32'h100, 8'hFF);
    do_op("R3 R8 clear", 1'b1, 32'h104, 8'h81);
    do_op("R5 read clr addr", 1'b0, 32'h104, 8'h00);
    // R1: high address bits ignored
    do_op("R1 set high bits", 1'b1, 32'hE000_0108, 8'h5A);
    do_op("R1 read", 1'b0, 32'h2000_0108, 8'h00);
    // R12: 0x108 hits mask 1, not priority 0
    do_op("R12 read shadow", 1'b0, 32'h108, 8'h00);
    do_op("R2 prio set", 1'b1, 32'h110, 8'hC9);
    do_op("R3 prio clear", 1'b1, 32'h114, 8'h41);
    do_op("R4 prio direct", 1'b1, 32'h118, 8'hE4);
    do_op("R4 prio direct again", 1'b1, 32'h118, 8'h27);
    do_op("R4 R9 unmapped above single", 1'b1, 32'h11C, 8'hFF);
    do_op("R9 unmapped read", 1'b0, 32'h11C, 8'h00);
    do_op("R4 read", 1'b0, 32'h118, 8'h00);
    do_op("R10 no change write", 1'b1, 32'h118, 8'h27);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0: a = 32'h100; 1: a = 32'h104; 2: a = 32'h108; 3: a = 32'h10C;
        4: a = 32'h110; 5: a = 32'h114; 6: a = 32'h118; 7: a = 32'h11C;
        8: a = 32'h200; default: a = 32'h120;
      endcase
      a[31:29] = 3'($urandom_range(0, 7));
      do_op("random", 1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)));
    end
    for (int i = 0; i < NM; i++) do_op("final R5 mask", 1'b0, MB + 8*i, 8'h00);
    for (int j = 1; j < NP; j++) do_op("final R5 prio", 1'b0, PB + 8*j, 8'h00);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule